// File: doc/BRIEF.md
# Three-Wire Serial Master Shift Engine

This block is a host-programmed serial master for simple clocked shift peripherals. The peripherals use a serial clock, a data line from the master and a data line back to the master. The host loads one or two data bytes through a byte-wide register port. The transfer starts when the host finishes its write to the first-byte register. The engine then clocks the bits out most significant bit first. It shifts the returned bits into the same two registers, so that when the transfer ends they hold the peripheral's reply.

Completion shows as a flag in a status register. It can also raise an interrupt line. Configuration bits set the word length (one or two bytes), the serial clock polarity, the interrupt enable and a turnaround mode. In turnaround mode the data-out pad is released and read back as the serial input, for peripherals that answer on the same wire. The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Top module: `serial3w_master`

## Requirements
- R1: Register addresses are: 0 first byte, 1 second byte, 2 configuration, 3 status. A write commits on the cycle after the falling edge of `wrStrobe`, using the address and data held while the strobe was high. Committing a write to address 0 starts a transfer. Writing address 1 or 2 alone starts none.
- R2: With configuration bit 0 clear (one-byte mode), exactly 8 bits are sent, most significant bit first, from the first-byte register. The second-byte register is left unchanged.
- R3: With configuration bit 0 set (two-byte mode), 16 bits are sent. The first-byte register goes first, then the second-byte register, each most significant bit first.
- R4: When the transfer ends, the returned bits can be read back. The first bits received form the first-byte register and the later bits form the second-byte register (two-byte mode only).
- R5: Status bit 7 reads 0 while a transfer runs and 1 once it has ended. The other status bits read 0. The status register reads 0x80 after reset.
- R6: With configuration bit 2 set, `irq` follows the done flag. With the bit clear, `irq` stays 0. `irq` falls when a transfer starts.
- R7: The serial clock period is `CLK_DIV` system clocks, and the line idles low. The master changes `serOut` on the falling edge of `serClk` and samples input on the rising edge. Configuration bit 1 inverts the clock: it idles high and both edges swap roles.
- R8: With configuration bit 3 set, `serOutEn` is 0 and input bits are taken from `serPad` instead of `serIn`.
- R9: While a transfer runs, writes to any register have no effect. This includes a second write to address 0, which does not restart the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wrData | input | 8 | Host write data |
| wrStrobe | input | 1 | Write strobe; the write commits after its falling edge |
| rdData | output | 8 | Read data for `addr` |
| irq | output | 1 | Completion interrupt |
| serClk | output | 1 | Serial clock |
| serOut | output | 1 | Serial data to the peripheral |
| serOutEn | output | 1 | Output enable for the `serOut` pad |
| serIn | input | 1 | Serial data from the peripheral |
| serPad | input | 1 | Level seen on the data-out pad, used as input in turnaround mode |

## Verification
A peripheral model records every bit the master presents at each sampling edge and answers with a known reply word. The transfers cover one-byte and two-byte frames, normal and inverted clock, and turnaround. In the turnaround runs `serIn` and `serPad` carry complementary data, so the readback shows which pin was sampled. The reply and payload patterns are asymmetric bytes, which exposes reversed bit order and swapped bytes. Mid-transfer reads and writes show that the status flag drops, that the interrupt clears, and that host writes cannot disturb or restart a running frame.

// File: rtl/s3w_pkg.sv
package s3w_pkg;
  localparam logic [1:0] ADDR_HI  = 2'd0;
  localparam logic [1:0] ADDR_LO  = 2'd1;
  localparam logic [1:0] ADDR_CFG = 2'd2;
  localparam logic [1:0] ADDR_ST  = 2'd3;

  typedef struct packed {
    logic turnaround;
    logic intEnable;
    logic clkInvert;
    logic twoByte;
  } s3wCfg_t;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic loadCfg;
    logic sampleEdge;
    logic shiftEdge;
  } s3wStrobes_t;
endpackage

// File: rtl/s3w_control.sv
module s3w_control
  import s3w_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  addr,
  input  logic        wrStrobe,
  input  logic        twoByte,
  output s3wStrobes_t str,
  output logic        busy,
  output logic        done,
  output logic        phase
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam int BITS_MAX = 16;
  localparam int BW = $clog2(BITS_MAX);

  logic          strobeDly;
  logic [1:0]    holdAddr;
  logic [CW-1:0] halfCnt;
  logic [BW-1:0] bitCnt;
  logic          trailing, commit, halfDone, lastBit;

  assign trailing = strobeDly & ~wrStrobe;
  assign commit   = trailing & ~busy;
  assign halfDone = busy && (halfCnt == HALF_LAST);
  assign lastBit  = (bitCnt == (twoByte ? BW'(15) : BW'(7)));

  always_comb begin
    str.loadHi     = commit && (holdAddr == ADDR_HI);
    str.loadLo     = commit && (holdAddr == ADDR_LO);
    str.loadCfg    = commit && (holdAddr == ADDR_CFG);
    str.sampleEdge = halfDone & ~phase;
    str.shiftEdge  = halfDone & phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeDly <= 1'b0;
      holdAddr  <= '0;
      halfCnt   <= '0;
      bitCnt    <= '0;
      phase     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b1;
    end else begin
      strobeDly <= wrStrobe;
      if (wrStrobe) holdAddr <= addr;
      if (str.loadHi) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        halfCnt <= '0;
        bitCnt  <= '0;
        phase   <= 1'b0;
      end else if (busy) begin
        if (halfDone) begin
          halfCnt <= '0;
          phase   <= ~phase;
          if (str.shiftEdge) begin
            if (lastBit) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  // R5: done flag is low for the whole of a running transfer
  a_r5_done_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  // R1: a transfer begins only from a committed first-byte write
  a_r1_start_from_hi: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(str.loadHi));
  // R3: bit counter never passes the frame length
  a_r3_bit_limit: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= (twoByte ? BW'(15) : BW'(7))));
endmodule

// File: rtl/s3w_datapath.sv
module s3w_datapath
  import s3w_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic [7:0]  wrData,
  input  s3wStrobes_t str,
  input  logic        phase,
  input  logic        serIn,
  input  logic        serPad,
  output logic [7:0]  hiReg,
  output logic [7:0]  loReg,
  output s3wCfg_t     cfg,
  output logic        serClk,
  output logic        serOut,
  output logic        serOutEn
);
  logic [7:0] holdData;
  logic       rxBit;

  assign serOut   = hiReg[7];
  assign serOutEn = ~cfg.turnaround;
  assign serClk   = phase ^ cfg.clkInvert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      hiReg    <= '0;
      loReg    <= '0;
      cfg      <= '0;
      rxBit    <= 1'b0;
    end else begin
      if (wrStrobe) holdData <= wrData;
      if (str.loadHi)  hiReg <= holdData;
      if (str.loadLo)  loReg <= holdData;
      if (str.loadCfg) cfg   <= s3wCfg_t'(holdData[3:0]);
      if (str.sampleEdge) rxBit <= cfg.turnaround ? serPad : serIn;
      if (str.shiftEdge) begin
        if (cfg.twoByte) {hiReg, loReg} <= {hiReg[6:0], loReg, rxBit};
        else             hiReg          <= {hiReg[6:0], rxBit};
      end
    end
  end

  // R7: the data line moves only on a launch edge or a register load
  a_r7_out_launch_only: assert property (@(posedge clk) disable iff (!rstN)
    (!str.loadHi && !str.shiftEdge) |=> $stable(serOut));
endmodule

// File: rtl/serial3w_master.sv
module serial3w_master
  import s3w_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrStrobe,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       serClk,
  output logic       serOut,
  output logic       serOutEn,
  input  logic       serIn,
  input  logic       serPad
);
  s3wStrobes_t str;
  s3wCfg_t     cfg;
  logic        busy, done, phase;
  logic [7:0]  hiReg, loReg;

  s3w_control #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrStrobe(wrStrobe),
    .twoByte(cfg.twoByte), .str(str), .busy(busy), .done(done), .phase(phase)
  );

  s3w_datapath uData (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData), .str(str),
    .phase(phase), .serIn(serIn), .serPad(serPad), .hiReg(hiReg), .loReg(loReg),
    .cfg(cfg), .serClk(serClk), .serOut(serOut), .serOutEn(serOutEn)
  );

  assign irq = done & cfg.intEnable;

  always_comb begin
    unique case (addr)
      ADDR_HI:  rdData = hiReg;
      ADDR_LO:  rdData = loReg;
      ADDR_CFG: rdData = {4'b0, cfg};
      default:  rdData = {done, 7'b0};
    endcase
  end

  // R6: the interrupt is low from the first cycle of a transfer
  a_r6_irq_clear_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !irq);
  // R7: between transfers the clock rests at its idle level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serClk == cfg.clkInvert));
endmodule

// File: tb/sim_serial3w_master.sv
module sim_serial3w_master;
  localparam int CLK_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrStrobe = 1'b0;
  logic [7:0] rdData;
  logic       irq, serClk, serOut, serOutEn;
  logic       serIn, serPad;

  int checks = 0;
  int fails = 0;

  typedef struct { logic [15:0] sent; int nBits; } item_t;
  item_t sbQ[$];

  logic [15:0] resp = '0;
  int          periIdx = 0;
  logic        periInv = 1'b0;
  logic        turnMode = 1'b0;
  logic        periBit;
  logic [15:0] gotBits = '0;
  int          gotCnt = 0;
  int          sinceEdge = 0;
  logic        prevClk = 1'b0;

  always #10 clk = ~clk;

  assign periBit = (periIdx < 16) ? resp[15 - periIdx] : 1'b0;
  assign serIn   = turnMode ? ~periBit : periBit;
  assign serPad  = turnMode ? periBit : ~periBit;

  serial3w_master #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrStrobe(wrStrobe),
    .rdData(rdData), .irq(irq), .serClk(serClk), .serOut(serOut),
    .serOutEn(serOutEn), .serIn(serIn), .serPad(serPad)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Peripheral model and scoreboard monitor (R2, R3, R7)
  always @(negedge clk) begin
    if (rstN && serClk !== prevClk && serClk == ~periInv) begin
      gotBits = {gotBits[14:0], serOut};
      gotCnt++;
      if (gotCnt > 1) chk("R7 serial clock period", 16'(sinceEdge), 16'(CLK_DIV - 1));
      sinceEdge = 0;
      periIdx++;
    end else begin
      sinceEdge++;
    end
    prevClk = serClk;
    if (sbQ.size() > 0 && gotCnt == sbQ[0].nBits) begin
      item_t it;
      it = sbQ.pop_front();
      if (it.nBits == 8) chk("R2 one-byte bits sent", {8'h00, gotBits[7:0]}, it.sent);
      else               chk("R3 two-byte bits sent", gotBits, it.sent);
      gotCnt = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic startXfer(input logic [7:0] cfgV, input logic [7:0] hi,
                           input logic [7:0] lo, input logic [15:0] r);
    item_t it;
    periInv  = cfgV[1];
    turnMode = cfgV[3];
    wr(2'd2, cfgV);
    wr(2'd1, lo);
    resp = r;
    periIdx = 0;
    it.nBits = cfgV[0] ? 16 : 8;
    it.sent  = cfgV[0] ? {hi, lo} : {8'h00, hi};
    sbQ.push_back(it);
    wr(2'd0, hi);
  endtask

  task automatic waitDone();
    logic [7:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, v);
      if (v[7]) break;
    end
    chk("R5 done after transfer", {8'h00, v}, 16'h0080);
    repeat (2) @(negedge clk);
    chk("R2/R3 scoreboard drained", 16'(sbQ.size()), 16'd0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R5, R6, R7, R8)
    rd(2'd3, v); chk("R5 reset status", {8'h00, v}, 16'h0080);
    chk("R6 reset irq", {15'b0, irq}, 16'd0);
    chk("R7 reset clock idle", {15'b0, serClk}, 16'd0);
    chk("R8 reset output enabled", {15'b0, serOutEn}, 16'd1);

    // R1: second-byte and config writes start nothing
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h5A);
    repeat (20) @(negedge clk);
    rd(2'd3, v); chk("R1 no start on second byte", {8'h00, v}, 16'h0080);
    chk("R1 no clock edges", 16'(gotCnt), 16'd0);
    rd(2'd1, v); chk("R1 second byte stored", {8'h00, v}, 16'h005A);

    // R2, R4: one-byte frame, second byte untouched
    startXfer(8'h00, 8'hA5, 8'h3C, 16'h6E00);
    waitDone();
    rd(2'd0, v); chk("R4 one-byte reply", {8'h00, v}, 16'h006E);
    rd(2'd1, v); chk("R2 second byte unchanged", {8'h00, v}, 16'h003C);

    // R3, R4: two-byte frame
    startXfer(8'h01, 8'h81, 8'h7E, 16'hC3A9);
    waitDone();
    rd(2'd0, v); chk("R4 two-byte high reply", {8'h00, v}, 16'h00C3);
    rd(2'd1, v); chk("R4 two-byte low reply", {8'h00, v}, 16'h00A9);

    // R7: inverted clock polarity
    periInv = 1'b1;
    wr(2'd2, 8'h03);
    chk("R7 inverted idle high", {15'b0, serClk}, 16'd1);
    startXfer(8'h03, 8'h12, 8'hF0, 16'h5AA5);
    waitDone();
    rd(2'd0, v); chk("R7 inverted high reply", {8'h00, v}, 16'h005A);
    rd(2'd1, v); chk("R7 inverted low reply", {8'h00, v}, 16'h00A5);
    chk("R7 inverted rests high", {15'b0, serClk}, 16'd1);

    // R5, R6, R9: interrupt and writes while busy
    startXfer(8'h04, 8'h9B, 8'h11, 16'h2D00);
    rd(2'd3, v); chk("R5 status low while busy", {8'h00, v}, 16'h0000);
    chk("R6 irq clear on start", {15'b0, irq}, 16'd0);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hEE);
    wr(2'd2, 8'h00);
    waitDone();
    chk("R6 irq raised when enabled", {15'b0, irq}, 16'd1);
    rd(2'd0, v); chk("R9 first byte not overwritten", {8'h00, v}, 16'h002D);
    rd(2'd1, v); chk("R9 second byte not overwritten", {8'h00, v}, 16'h0011);
    rd(2'd2, v); chk("R9 config not overwritten", {8'h00, v}, 16'h0004);
    repeat (40) @(negedge clk);
    chk("R9 no restart", 16'(gotCnt), 16'd0);

    // R8: turnaround on a two-byte frame
    startXfer(8'h09, 8'h47, 8'hB8, 16'h9C63);
    chk("R8 output released", {15'b0, serOutEn}, 16'd0);
    waitDone();
    rd(2'd0, v); chk("R8 pad high reply", {8'h00, v}, 16'h009C);
    rd(2'd1, v); chk("R8 pad low reply", {8'h00, v}, 16'h0063);
    chk("R6 irq off when disabled", {15'b0, irq}, 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule